// File: doc/BRIEF.md
# Direct Digital Sine Synthesizer

This block produces a stream of signed sine amplitude samples for an external digital-to-analog converter. A 32-bit phase register grows by a tuning step on every clock and wraps modulo 2^32. Its ten most significant bits, plus a ten-bit phase shift, form a full-cycle table address. Only one quarter of the sine cycle is stored. The two quadrant bits of the address reflect the index and flip the sign, which rebuilds the whole wave.

Two tuning steps are present at all times. A select input picks which one is added at the next edge. The phase register is never reloaded, so a frequency change starts from the current phase with no settling time (frequency shift keying). The phase shift input only moves the read address and leaves the phase register alone (phase shift keying). A two-state controller drives the valid flag. `ST_HOLD` is entered on reset. The transition `ST_HOLD -> ST_STREAM` happens on the first clock after reset is released. `ST_STREAM` holds until the next reset.

Top module: `dds_core`

## Requirements
- R1: While `rst` is high, the phase register is cleared to zero, `sample_o` reads 0 and `sample_vld_o` reads 0.
- R2: On each clock edge with `rst` low, the phase register gains the selected tuning step, modulo 2^32.
- R3: The table address is the top 10 bits of the phase register plus `phase_shift_i`, modulo 1024.
- R4: For address a, the sample equals round(2047*sin(2*pi*(a+0.5)/1024)), with halves rounded away from zero, as 12-bit two's complement. The value -2048 never appears.
- R5: `sample_o` is registered. After an edge it shows the sample for the phase value and shift that were present before that edge.
- R6: `sample_vld_o` rises on the first clock after reset is released and stays high until the next reset (ST_HOLD to ST_STREAM).
- R7: When `tone_sel_i` is 1, `tune_b_i` is added; when it is 0, `tune_a_i` is added. The choice applies at the next edge and leaves the accumulated phase continuous.
- R8: `phase_shift_i` moves only the read address. The phase trajectory is unchanged by it.
- R9: The phase register wraps past 2^32 without a discontinuity in the addressed sequence.
- R10: Samples half a cycle apart (a and a+512) are exact negatives. Addresses 255 and 256 mirror each other and read the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_a_i | input | 32 | Tuning step used when the select input is 0 |
| tune_b_i | input | 32 | Tuning step used when the select input is 1 |
| tone_sel_i | input | 1 | Tuning step select |
| phase_shift_i | input | 10 | Address offset for phase keying |
| sample_o | output | 12 | Signed amplitude sample |
| sample_vld_o | output | 1 | Sample valid |

## Verification
The hardest case to reach from the ports is a chosen table address, because the phase register is only reachable through accumulation. The stimulus therefore resets the block, holds both tuning steps at zero to freeze the phase at zero, and then sweeps the phase shift input. That sweep places the read on chosen quadrant edges and mirror points, so the symmetry in R10 can be compared directly. During the vector runs, the bench keeps its own model of the phase register. It feeds that model every tuning step, select and shift that it drives, so that it can predict the sample produced after each FSK switch, each PSK jump and each wrap.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        QD_RISE     = 2'd0,
        QD_FALL     = 2'd1,
        QD_NEG_RISE = 2'd2,
        QD_NEG_FALL = 2'd3
    } quad_e;

    typedef enum logic {
        ST_HOLD   = 1'b0,
        ST_STREAM = 1'b1
    } ctl_state_e;

    localparam real TWO_PI = 6.283185307179586;

    // Magnitude of the stored quarter-wave entry at index idx, for a full cycle of
    // full_len points, with peak amplitude amp and half-step centred sampling.
    function automatic int quarter_mag(input int idx, input int full_len, input int amp);
        real v;
        v = amp * $sin(TWO_PI * (idx + 0.5) / full_len);
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] acc_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
        end else begin
            acc_o <= acc_o + step_i;
        end
    end

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
    parameter int IDX_W = 8,
    parameter int MAG_W = 11
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [MAG_W-1:0] mag_o
);

    localparam int DEPTH    = 1 << IDX_W;
    localparam int FULL_LEN = DEPTH * 4;
    localparam int PEAK     = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [MAG_W-1:0] ENT_VAL =
            MAG_W'(dds_pkg::quarter_mag(g, FULL_LEN, PEAK));
        assign tbl[g] = ENT_VAL;
    end

    assign mag_o = tbl[idx_i];

endmodule

// File: rtl/dds_sine_map.sv
module dds_sine_map #(
    parameter int ADDR_W = 10,
    parameter int OUT_W  = 12
) (
    input  logic [ADDR_W-1:0]       addr_i,
    output logic signed [OUT_W-1:0] amp_o
);
    import dds_pkg::*;

    localparam int IDX_W = ADDR_W - 2;
    localparam int MAG_W = OUT_W - 1;

    quad_e            quad;
    logic [IDX_W-1:0] idx_raw;
    logic [IDX_W-1:0] idx_rd;
    logic [MAG_W-1:0] mag;
    logic signed [OUT_W-1:0] pos_val;

    assign quad    = quad_e'(addr_i[ADDR_W-1 -: 2]);
    assign idx_raw = addr_i[IDX_W-1:0];

    always_comb begin
        unique case (quad)
            QD_RISE, QD_NEG_RISE: idx_rd = idx_raw;
            QD_FALL, QD_NEG_FALL: idx_rd = ~idx_raw;
        endcase
    end

    dds_quarter_rom #(
        .IDX_W (IDX_W),
        .MAG_W (MAG_W)
    ) u_rom (
        .idx_i (idx_rd),
        .mag_o (mag)
    );

    assign pos_val = $signed({1'b0, mag});

    always_comb begin
        unique case (quad)
            QD_RISE, QD_FALL:         amp_o = pos_val;
            QD_NEG_RISE, QD_NEG_FALL: amp_o = -pos_val;
        endcase
    end

endmodule

// File: rtl/dds_core.sv
module dds_core #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 10,
    parameter int OUT_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ACC_W-1:0]         tune_a_i,
    input  logic [ACC_W-1:0]         tune_b_i,
    input  logic                     tone_sel_i,
    input  logic [ADDR_W-1:0]        phase_shift_i,
    output logic signed [OUT_W-1:0]  sample_o,
    output logic                     sample_vld_o
);
    import dds_pkg::*;

    localparam int TOP_LSB = ACC_W - ADDR_W;

    ctl_state_e              state_q;
    ctl_state_e              state_d;
    logic [ACC_W-1:0]        step;
    logic [ACC_W-1:0]        phase_acc;
    logic [ADDR_W-1:0]       rd_addr;
    logic signed [OUT_W-1:0] amp_next;

    assign step    = tone_sel_i ? tune_b_i : tune_a_i;
    assign rd_addr = phase_acc[ACC_W-1:TOP_LSB] + phase_shift_i;

    dds_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .acc_o  (phase_acc)
    );

    dds_sine_map #(
        .ADDR_W (ADDR_W),
        .OUT_W  (OUT_W)
    ) u_map (
        .addr_i (rd_addr),
        .amp_o  (amp_next)
    );

    always_comb begin
        unique case (state_q)
            ST_HOLD:   state_d = ST_STREAM;
            ST_STREAM: state_d = ST_STREAM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
        end else begin
            sample_o <= amp_next;
        end
    end

    assign sample_vld_o = (state_q == ST_STREAM);

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic [ACC_W-1:0]        tune_a_i,
    input logic [ACC_W-1:0]        tune_b_i,
    input logic                    tone_sel_i,
    input logic [ACC_W-1:0]        acc,
    input logic signed [OUT_W-1:0] sample_o,
    input logic                    sample_vld_o
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    // R2
    acc_a_step_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(tone_sel_i)) |-> (acc == $past(acc) + $past(tune_a_i)));

    // R7
    acc_b_step_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tone_sel_i)) |-> (acc == $past(acc) + $past(tune_b_i)));

    // R6
    vld_held_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> sample_vld_o);

    // R4
    no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
        sample_o != $signed({1'b1, {(OUT_W-1){1'b0}}}));

endmodule

bind dds_core dds_core_chk #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tune_a_i     (tune_a_i),
    .tune_b_i     (tune_b_i),
    .tone_sel_i   (tone_sel_i),
    .acc          (phase_acc),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o)
);

// File: tb/sim_dds_core.sv
module sim_dds_core;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        tune_a = '0;
    logic [31:0]        tune_b = '0;
    logic               sel = 1'b0;
    logic [9:0]         shift = '0;
    logic signed [11:0] sample;
    logic               vld;

    int checks = 0;
    int bad = 0;

    logic [31:0]        acc_m = '0;
    logic signed [11:0] exp_q = '0;
    bit                 have_exp = 1'b0;

    always #10 clk = ~clk;

    dds_core u0 (
        .clk           (clk),
        .rst           (rst),
        .tune_a_i      (tune_a),
        .tune_b_i      (tune_b),
        .tone_sel_i    (sel),
        .phase_shift_i (shift),
        .sample_o      (sample),
        .sample_vld_o  (vld)
    );

    function automatic logic signed [11:0] sine_of(input int a);
        real v;
        real m;
        int  r;
        v = 2047.0 * $sin(6.283185307179586 * (a + 0.5) / 1024.0);
        m = (v < 0.0) ? -v : v;
        r = $rtoi(m + 0.5);
        return (v < 0.0) ? 12'(-r) : 12'(r);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One cycle: check the result of the previous edge, then drive the next inputs.
    task automatic step(input logic [31:0] wa, input logic [31:0] wb,
                        input logic s, input logic [9:0] ofs);
        @(negedge clk);
        if (have_exp) begin
            chk("R4/R5/R7/R8/R9 sample", 32'(sample), 32'(exp_q));
            chk("R6 valid", 32'(vld), 32'd1);
        end
        tune_a = wa;
        tune_b = wb;
        sel    = s;
        shift  = ofs;
        exp_q  = sine_of(int'(10'(acc_m[31:22] + ofs)));
        acc_m  = acc_m + (s ? wb : wa);
        have_exp = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tune_a = '0;
        tune_b = '0;
        sel = 1'b0;
        shift = '0;
        @(negedge clk);
        @(negedge clk);
        // R1: state while reset is held
        chk("R1 sample", 32'(sample), 32'd0);
        chk("R1 valid", 32'(vld), 32'd0);
        acc_m = '0;
        have_exp = 1'b0;
        rst = 1'b0;
    endtask

    // fields: tune_a, tune_b, sel, shift, cycles
    localparam logic [82:0] VEC [8] = '{
        {32'h0100_0000, 32'h0000_0000, 1'b0, 10'd0,   8'd40},
        {32'h0040_0000, 32'h0000_0000, 1'b0, 10'd0,   8'd30},
        {32'h0123_4567, 32'h0400_0000, 1'b1, 10'd0,   8'd20},
        {32'h0123_4567, 32'h0400_0000, 1'b0, 10'd0,   8'd20},
        {32'h0123_4567, 32'h0400_0000, 1'b1, 10'd256, 8'd20},
        {32'hFFC0_0000, 32'h0000_0000, 1'b0, 10'd512, 8'd30},
        {32'h8000_0000, 32'h0000_0000, 1'b0, 10'd0,   8'd10},
        {32'h3333_3333, 32'h0000_0000, 1'b0, 10'd100, 8'd60}
    };

    localparam int SWEEP [10] = '{0, 512, 255, 767, 256, 768, 511, 1023, 300, 812};

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic signed [11:0] seen [10];

        do_reset();

        // R2 R7 R8 R9: table-driven runs with a running phase model
        for (int v = 0; v < 8; v++) begin
            for (int c = 0; c < int'(VEC[v][7:0]); c++) begin
                step(VEC[v][82:51], VEC[v][50:19], VEC[v][18], VEC[v][17:8]);
            end
        end
        step(32'd0, 32'd0, 1'b0, 10'd0);

        // R9: wrap from the top of the phase range
        do_reset();
        step(32'hFFFF_FFFF, 32'd0, 1'b0, 10'd0);
        step(32'h0000_0001, 32'd0, 1'b0, 10'd0);
        step(32'h0000_0001, 32'd0, 1'b0, 10'd0);
        step(32'hFFC0_0000, 32'd0, 1'b0, 10'd0);
        step(32'd0, 32'd0, 1'b0, 10'd0);

        // R10 R3: frozen phase, sweep the shift across quadrant edges
        do_reset();
        for (int k = 0; k < 10; k++) begin
            step(32'd0, 32'd0, 1'b0, 10'(SWEEP[k]));
            @(posedge clk);
            @(negedge clk);
            seen[k] = sample;
            chk("R3 swept address", 32'(sample), 32'(sine_of(SWEEP[k])));
            have_exp = 1'b0;
        end
        for (int p = 0; p < 10; p += 2) begin
            chk("R10 half-cycle negation", 32'(seen[p + 1]), 32'(-seen[p]));
        end
        chk("R10 mirror 255/256", 32'(seen[2]), 32'(seen[4]));

        // R1: reset mid-stream returns to cleared state
        step(32'h0100_0000, 32'd0, 1'b0, 10'd0);
        step(32'h0100_0000, 32'd0, 1'b0, 10'd0);
        do_reset();
        step(32'd0, 32'd0, 1'b0, 10'd0);
        step(32'd0, 32'd0, 1'b0, 10'd0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule